// File: doc/BRIEF.md
# Per-Channel Amplitude Serializer

This block serves one detector channel after its peak detector and amplitude converter. A single-cycle peak strobe starts an event. The block then waits a programmable number of serial-clock cycles while the conversion settles. It takes the amplitude code on the edge that ends the wait. It sends that code out on a line that runs at two bits per clock cycle. The frame is a one-bit-time high start flag, then the code with the most significant bit first, and the line returns low after the last bit.

The double-rate line is given as two single-rate signals, one bit for the rising half of each clock cycle and one for the falling half. An external double-data-rate output cell merges them. After the frame the block drives a channel-reset pulse to the analog front end. It then raises `ready` again. A strobe that arrives while the block is busy is dropped, and a sticky flag records that a strobe was lost. The longest busy period is bounded so that the channel always rearms within a fixed dead-time budget.

Top module: `asr_amp_serializer`

## Requirements
- R1: After reset, `ready`=1, `chan_reset`=0, `ser_rise`=0, `ser_fall`=0 and `overflow`=0.
- R2: A strobe is accepted on edge E0 only when `ready` was 1 before that edge. The code is sampled on edge E0+d, where d is the value of `conv_delay` at E0 (d=0 samples at E0 itself). The first frame cycle is the cycle that follows the sampling edge.
- R3: A frame lasts 4 consecutive cycles. In each cycle the pair (`ser_rise`,`ser_fall`) is, in order: (1,D5), (D4,D3), (D2,D1), (D0,0).
- R4: Whenever the block is not sending a frame, both serial outputs are 0.
- R5: Directly after the last frame cycle, `chan_reset` is 1 for exactly 2 cycles. In the next cycle `ready` is 1 and `chan_reset` is 0.
- R6: `ready` goes to 0 on the edge that accepts a strobe and stays 0 until the reset pulse ends. `ready` and `chan_reset` are never 1 together.
- R7: A strobe sampled while `ready`=0 starts no frame and does not change the frame in progress. It sets `overflow` to 1.
- R8: `overflow`, once set, stays 1 until `rst_n` is asserted.
- R9: From the accepting edge, `ready` stays low for exactly d+6 cycles. With the largest delay setting this is 13 cycles, within a 16-cycle (100 ns at 160 MHz) budget.
- R10: The value of `amp_code` in any cycle other than the one that ends at the sampling edge does not affect the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock (160 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| peak_found | input | 1 | Peak strobe that starts an event |
| amp_code | input | 6 | Amplitude code from the converter |
| conv_delay | input | 3 | Conversion wait in clock cycles (4 = 25 ns) |
| ser_rise | output | 1 | Serial bit for the rising half of the cycle |
| ser_fall | output | 1 | Serial bit for the falling half of the cycle |
| chan_reset | output | 1 | Reset pulse to the analog channel |
| ready | output | 1 | Channel rearmed and able to take a strobe |
| overflow | output | 1 | Sticky flag: a strobe was lost while busy |

## Verification
The collision that matters is between the end of the reset pulse and a new strobe. The bench drives a strobe in the last cycle that `chan_reset` is high. It expects the strobe to be ignored, `overflow` to rise and `ready` to come up with no frame. It then drives a strobe with zero delay in the very first `ready` cycle. It expects that frame to start in the next cycle, back to back with the previous event. A strobe is also injected in the middle of a frame, and the scoreboard checks that the frame in flight keeps its bits and its timing.

// File: rtl/asr_pkg.sv
package asr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_RST   = 2'd3
   } asr_state_e;
endpackage

// File: rtl/asr_delay_timer.sv
module asr_delay_timer #(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= load_val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/asr_frame_shifter.sv
module asr_frame_shifter #(
   parameter int CODE_W = 6,
   parameter int PAIRS  = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              active_i,
   input  logic [IDX_W-1:0]  pair_idx_i,
   output logic              rise_o,
   output logic              fall_o
);
   localparam int SLOT_N = 2 * PAIRS;

   logic [CODE_W-1:0] word_q;
   logic [SLOT_N-1:0] slot_vec;
   logic [IDX_W:0]    base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (capture_i) word_q <= code_i;
   end

   // slot 0 is the start flag, then MSB down to LSB, then idle padding
   assign slot_vec[0] = 1'b1;
   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      assign slot_vec[i+1] = word_q[CODE_W-1-i];
   end
   for (genvar j = CODE_W + 1; j < SLOT_N; j++) begin : g_pad
      assign slot_vec[j] = 1'b0;
   end

   assign base   = {pair_idx_i, 1'b0};
   assign rise_o = active_i & slot_vec[base];
   assign fall_o = active_i & slot_vec[base + 1'b1];
endmodule

// File: rtl/asr_seq_ctrl.sv
module asr_seq_ctrl
   import asr_pkg::*;
#(
   parameter int DLY_W   = 3,
   parameter int PAIRS   = 4,
   parameter int IDX_W   = 2,
   parameter int RST_CYC = 2,
   parameter int RST_W   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             peak_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic             expired_i,
   output logic             timer_load_o,
   output logic [DLY_W-1:0] timer_val_o,
   output logic             capture_o,
   output logic             active_o,
   output logic [IDX_W-1:0] pair_idx_o,
   output logic             chan_reset_o,
   output logic             ready_o,
   output logic             overflow_o
);
   localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(PAIRS - 1);
   localparam logic [RST_W-1:0] RST_LOAD  = RST_W'(RST_CYC - 1);

   asr_state_e       st_q, st_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [RST_W-1:0] rc_q, rc_d;
   logic             ovf_q;

   always_comb begin
      st_d         = st_q;
      idx_d        = idx_q;
      rc_d         = rc_q;
      timer_load_o = 1'b0;
      timer_val_o  = delay_i - 1'b1;
      capture_o    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (peak_i) begin
               if (delay_i == '0) begin
                  capture_o = 1'b1;
                  idx_d     = '0;
                  st_d      = ST_SHIFT;
               end else begin
                  timer_load_o = 1'b1;
                  st_d         = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            if (expired_i) begin
               capture_o = 1'b1;
               idx_d     = '0;
               st_d      = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            if (idx_q == LAST_PAIR) begin
               rc_d = RST_LOAD;
               st_d = ST_RST;
            end else begin
               idx_d = idx_q + 1'b1;
            end
         end
         ST_RST: begin
            if (rc_q == '0) st_d = ST_IDLE;
            else            rc_d = rc_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         rc_q  <= '0;
         ovf_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         rc_q  <= rc_d;
         if (peak_i && st_q != ST_IDLE) ovf_q <= 1'b1;
      end
   end

   assign active_o     = (st_q == ST_SHIFT);
   assign pair_idx_o   = idx_q;
   assign chan_reset_o = (st_q == ST_RST);
   assign ready_o      = (st_q == ST_IDLE);
   assign overflow_o   = ovf_q;
endmodule

// File: rtl/asr_amp_serializer.sv
module asr_amp_serializer #(
   parameter int CODE_W          = 6,
   parameter int DLY_W           = 3,
   parameter int RST_CYC         = 2,
   parameter int DEAD_BUDGET_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              peak_found,
   input  logic [CODE_W-1:0] amp_code,
   input  logic [DLY_W-1:0]  conv_delay,
   output logic              ser_rise,
   output logic              ser_fall,
   output logic              chan_reset,
   output logic              ready,
   output logic              overflow
);
   localparam int SLOTS    = CODE_W + 1;
   localparam int PAIRS    = (SLOTS + 1) / 2;
   localparam int IDX_W    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
   localparam int RST_W    = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
   localparam int MAX_BUSY = (2 ** DLY_W - 1) + PAIRS + RST_CYC;

   if (CODE_W < 1) begin : g_bad_code
      $error("CODE_W must be at least 1");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end
   if (MAX_BUSY > DEAD_BUDGET_CYC) begin : g_bad_budget
      $error("worst-case busy time exceeds the dead-time budget");
   end

   logic             tmr_load, tmr_expired, capture, active;
   logic [DLY_W-1:0] tmr_val;
   logic [IDX_W-1:0] pair_idx;

   asr_delay_timer #(.DLY_W(DLY_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_expired)
   );

   asr_seq_ctrl #(
      .DLY_W   (DLY_W),
      .PAIRS   (PAIRS),
      .IDX_W   (IDX_W),
      .RST_CYC (RST_CYC),
      .RST_W   (RST_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .peak_i       (peak_found),
      .delay_i      (conv_delay),
      .expired_i    (tmr_expired),
      .timer_load_o (tmr_load),
      .timer_val_o  (tmr_val),
      .capture_o    (capture),
      .active_o     (active),
      .pair_idx_o   (pair_idx),
      .chan_reset_o (chan_reset),
      .ready_o      (ready),
      .overflow_o   (overflow)
   );

   asr_frame_shifter #(
      .CODE_W (CODE_W),
      .PAIRS  (PAIRS),
      .IDX_W  (IDX_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_i  (capture),
      .code_i     (amp_code),
      .active_i   (active),
      .pair_idx_i (pair_idx),
      .rise_o     (ser_rise),
      .fall_o     (ser_fall)
   );
endmodule

// File: rtl/asr_amp_serializer_chk.sv
module asr_amp_serializer_chk #(
   parameter int BUSY_LIMIT = 16
) (
   input logic clk,
   input logic rst_n,
   input logic peak_found,
   input logic ser_rise,
   input logic ser_fall,
   input logic chan_reset,
   input logic ready,
   input logic overflow
);
   logic [7:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 busy_cnt <= '0;
      else if (ready)             busy_cnt <= '0;
      else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 1'b1;
   end

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!ser_rise && !ser_fall));

   assert_ready_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && chan_reset));

   assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && peak_found) |=> !ready);

   assert_reset_then_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_reset) |-> ready);

   assert_busy_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && peak_found) |=> overflow);

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_dead_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 8'(BUSY_LIMIT));
endmodule

bind asr_amp_serializer asr_amp_serializer_chk #(.BUSY_LIMIT(DEAD_BUDGET_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .peak_found (peak_found),
   .ser_rise   (ser_rise),
   .ser_fall   (ser_fall),
   .chan_reset (chan_reset),
   .ready      (ready),
   .overflow   (overflow)
);

// File: tb/asr_amp_serializer_bench.sv
module asr_amp_serializer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       peak_found = 1'b0;
   logic [5:0] amp_code = '0;
   logic [2:0] conv_delay = '0;
   logic       ser_rise, ser_fall, chan_reset, ready, overflow;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      logic [5:0] code;
      int         start;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   asr_amp_serializer u_asr_amp_serializer (
      .clk(clk), .rst_n(rst_n), .peak_found(peak_found), .amp_code(amp_code),
      .conv_delay(conv_delay), .ser_rise(ser_rise), .ser_fall(ser_fall),
      .chan_reset(chan_reset), .ready(ready), .overflow(overflow));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // driver: called at a negedge; waits for ready, pushes the expected frame
   task automatic send(input logic [5:0] code, input int d);
      while (!ready) @(negedge clk);
      peak_found = 1'b1;
      amp_code   = code;
      conv_delay = 3'(d);
      q.push_back('{code, cyc + 1 + d});
      @(negedge clk);
      peak_found = 1'b0;
      conv_delay = ~3'(d);
      if (d >= 2) begin
         amp_code = ~code;            // R10: disturbed before the sampling cycle
         repeat (d - 1) @(negedge clk);
         amp_code = code;
      end
      if (d >= 1) @(negedge clk);
      amp_code = ~code;               // R10: disturbed after the sampling edge
   endtask

   // monitor: scoreboard on the serial line
   initial begin
      int         st;
      logic [7:0] s;
      exp_t       e;
      forever begin
         @(negedge clk);
         if (rst_n && ser_rise === 1'b1) begin
            st = cyc;
            s[7] = ser_rise;
            s[6] = ser_fall;
            for (int k = 1; k < 4; k++) begin
               @(negedge clk);
               s[7-2*k] = ser_rise;
               s[6-2*k] = ser_fall;
            end
            chk("R3 closing slot low", int'(s[0]), 0);
            @(negedge clk);
            chk("R5 chan_reset first", int'(chan_reset), 1);
            chk("R6 ready low in reset", int'(ready), 0);
            @(negedge clk);
            chk("R5 chan_reset second", int'(chan_reset), 1);
            @(negedge clk);
            chk("R5 chan_reset ended", int'(chan_reset), 0);
            chk("R9 rearmed after d+6", int'(ready), 1);
            if (q.size() == 0) begin
               chk("R7 unexpected frame", 1, 0);
            end else begin
               e = q.pop_front();
               chk("R3 R10 frame code", int'(s[6:1]), int'(e.code));
               chk("R2 frame start cycle", st, e.start);
            end
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", int'(ready), 1);
      chk("R1 chan_reset", int'(chan_reset), 0);
      chk("R1 ser_rise", int'(ser_rise), 0);
      chk("R1 ser_fall", int'(ser_fall), 0);
      chk("R1 overflow", int'(overflow), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R10: several codes and delays
      send(6'h2A, 4);
      send(6'h3F, 0);
      send(6'h00, 7);
      send(6'h15, 1);
      send(6'h01, 2);
      send(6'h20, 3);
      send(6'h3E, 5);
      send(6'h0C, 6);
      repeat (3) @(negedge clk);
      chk("R4 idle line", int'(ser_rise | ser_fall), 0);
      chk("R7 no overflow yet", int'(overflow), 0);

      // R7: strobe in the middle of a frame
      send(6'h29, 2);
      chk("R6 busy during frame", int'(ready), 0);
      peak_found = 1'b1;
      @(negedge clk);
      peak_found = 1'b0;
      chk("R7 overflow set mid-frame", int'(overflow), 1);
      repeat (10) @(negedge clk);
      // R8: stays set across another frame
      send(6'h16, 0);
      repeat (10) @(negedge clk);
      chk("R8 overflow held", int'(overflow), 1);

      // R8: cleared only by reset
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 overflow cleared", int'(overflow), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // collision: strobe in last reset cycle, then strobe in first ready cycle
      send(6'h33, 1);
      repeat (5) @(negedge clk);
      chk("R5 last reset cycle", int'(chan_reset), 1);
      peak_found = 1'b1;
      amp_code   = 6'h07;
      conv_delay = 3'd0;
      @(negedge clk);
      peak_found = 1'b0;
      chk("R7 ignored strobe keeps ready", int'(ready), 1);
      chk("R7 ignored strobe sets overflow", int'(overflow), 1);
      chk("R4 no frame from ignored strobe", int'(ser_rise | ser_fall), 0);
      send(6'h2D, 0);
      repeat (12) @(negedge clk);
      chk("R3 all frames seen", q.size(), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule